// File: doc/BRIEF.md
# Effective Address Mode Decoder

This block turns the 6-bit mode/register field of an instruction into an addressing descriptor. The descriptor has a register number, a set of mode flags, a 32-bit displacement or absolute address, up to two further 32-bit immediate words, and an illegal-mode indication. When the mode needs 16-bit extension words, the block pulls them from an instruction-word stream over a valid/ready handshake. It reports how many extension bytes it took. It does not fetch the extension words of the indexed modes. It only flags those modes, and a separate indexed-extension decoder reads those words afterwards.

A request is taken while `req_ready` is high. The block then pulls the words it needs, if any. It raises `done` for exactly one cycle, and the descriptor is valid in that cycle. The descriptor stays held until the next request is taken. If the word stream reports a fetch fault, the decode stops at once and `bus_err` is set in the done cycle.

Top module: `ea_mode_decoder`

## Requirements
- R1: The mode is `mode_reg[5:3]` and the register field is `mode_reg[2:0]`. `reg_num` is the register field for mode 0 and for mode 7. It is 8 plus the register field for modes 1 to 6.
- R2: The flag bits are: bit0 direct, bit1 indirect, bit2 postincrement, bit3 predecrement, bit4 offset, bit5 indexed, bit6 absolute, bit7 PC-relative, bit8 immediate. Modes 0 and 1 give 0x001, mode 2 gives 0x002, mode 3 gives 0x004 and mode 4 gives 0x008. None of these modes takes a word, so `adv_bytes` is 0.
- R3: Mode 5 takes one word and sign-extends it from 16 to 32 bits into `disp`. The flags are 0x010 and `adv_bytes` is 2.
- R4: Mode 6 sets flags 0x020, and mode 7 register 3 sets flags 0x0A0. Neither takes a word, so `adv_bytes` is 0 and the indexed decoder reads the extension.
- R5: Mode 7 register 0 takes one word, sign-extended into `disp`, with `adv_bytes` 2. Mode 7 register 1 takes two words, high word first, with `adv_bytes` 4. Both set flags 0x040.
- R6: Mode 7 register 2 takes one sign-extended word into `disp`. The flags are 0x090 and `adv_bytes` is 2.
- R7: Mode 7 registers 5, 6 and 7 set `illegal` and take no word. The flags are 0 and `adv_bytes` is 0.
- R8: Mode 7 register 4 is immediate, with flags 0x100. For a `data_size` of 1, one word is taken and its low byte is sign-extended. For a `data_size` of 2, one word is taken and sign-extended from 16 bits. Both give `adv_bytes` 2.
- R9: Immediate data of 4, 8 or 12 bytes takes 2, 4 or 6 words, packed high word first. The result fills `disp`, then `ext1`, then `ext2`, and unused words read 0. `adv_bytes` equals the size.
- R10: A word offered with `wd_fault` high ends the decode with `bus_err` set and `illegal` clear. `adv_bytes` then counts only the words taken before the fault.
- R11: `done` lasts exactly one cycle. `req_ready` is low from the accepting edge until `done`, and is high again in the cycle after `done`. `wd_ready` is high only while words are still owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Decode request |
| req_ready | output | 1 | Block idle, request taken |
| mode_reg | input | 6 | Mode (5:3) and register (2:0) field |
| data_size | input | 4 | Operand size in bytes, for immediates |
| wd_valid | input | 1 | Extension word offered |
| wd_ready | output | 1 | Block wants an extension word |
| wd_data | input | 16 | Extension word |
| wd_fault | input | 1 | Fetch fault on the offered word |
| done | output | 1 | One-cycle descriptor strobe |
| bus_err | output | 1 | Decode ended by a fetch fault |
| illegal | output | 1 | Illegal mode 7 register field |
| reg_num | output | 4 | Register number |
| flags | output | 9 | Mode flags |
| disp | output | 32 | Displacement, absolute address or first immediate word |
| ext1 | output | 32 | Second immediate word |
| ext2 | output | 32 | Third immediate word |
| adv_bytes | output | 4 | Extension bytes taken |

## Verification
The assertions assume that `mode_reg` and `data_size` matter only in the accepting cycle. They also assume that `wd_fault` is read only together with `wd_valid`, and that `data_size` is 0 to 12. The bench keeps to these limits: it changes its inputs only on falling edges, and it offers a request only while `req_ready` is high. It also offers words only while `wd_ready` is high, and it raises the fault flag on exactly the word it means to fail.

// File: rtl/ea_mode_decoder.sv
module ea_mode_decoder #(
  parameter int MAX_WORDS = 6,
  localparam int CNT_W = $clog2(MAX_WORDS + 1),
  localparam int ACC_W = 16 * MAX_WORDS
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [5:0]  mode_reg,
  input  logic [3:0]  data_size,
  input  logic        wd_valid,
  output logic        wd_ready,
  input  logic [15:0] wd_data,
  input  logic        wd_fault,
  output logic        done,
  output logic        bus_err,
  output logic        illegal,
  output logic [3:0]  reg_num,
  output logic [8:0]  flags,
  output logic [31:0] disp,
  output logic [31:0] ext1,
  output logic [31:0] ext2,
  output logic [CNT_W:0] adv_bytes
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DONE} st_t;

  st_t              st;
  logic [5:0]       mr;
  logic [3:0]       sz;
  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] cnt;
  logic             err;

  function automatic logic [CNT_W-1:0] need_f(input logic [5:0] m, input logic [3:0] s);
    logic [CNT_W-1:0] n;
    n = '0;
    if (m[5:3] == 3'd5) n = 1;
    else if (m[5:3] == 3'd7) begin
      case (m[2:0])
        3'd0, 3'd2: n = 1;
        3'd1:       n = 2;
        3'd4: n = CNT_W'(s > 0) + CNT_W'(s > 2) + CNT_W'(2 * (s > 4)) + CNT_W'(2 * (s > 8));
        default:    n = '0;
      endcase
    end
    return n;
  endfunction

  wire [CNT_W-1:0] need_in  = need_f(mode_reg, data_size);
  wire [CNT_W-1:0] need_cur = need_f(mr, sz);
  wire [CNT_W-1:0] cnt_inc  = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      mr  <= '0;
      sz  <= '0;
      acc <= '0;
      cnt <= '0;
      err <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          mr  <= mode_reg;
          sz  <= data_size;
          acc <= '0;
          cnt <= '0;
          err <= 1'b0;
          st  <= (need_in == '0) ? S_DONE : S_FETCH;
        end
        S_FETCH: if (wd_valid) begin
          if (wd_fault) begin
            err <= 1'b1;
            st  <= S_DONE;
          end else begin
            acc <= {acc[ACC_W-17:0], wd_data};
            cnt <= cnt_inc;
            if (cnt_inc == need_cur) st <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign wd_ready  = (st == S_FETCH);
  assign done      = (st == S_DONE);
  assign bus_err   = err;
  assign adv_bytes = {cnt, 1'b0};

  wire [2:0] md = mr[5:3];
  wire [2:0] rf = mr[2:0];
  wire       is_imm = (md == 3'd7) && (rf == 3'd4);

  assign illegal = (md == 3'd7) && (rf > 3'd4) && !err;
  assign reg_num = (md == 3'd0 || md == 3'd7) ? {1'b0, rf} : {1'b1, rf};

  always_comb begin
    flags = '0;
    case (md)
      3'd0, 3'd1: flags[0] = 1'b1;
      3'd2:       flags[1] = 1'b1;
      3'd3:       flags[2] = 1'b1;
      3'd4:       flags[3] = 1'b1;
      3'd5:       flags[4] = 1'b1;
      3'd6:       flags[5] = 1'b1;
      default: case (rf)
        3'd0, 3'd1: flags[6] = 1'b1;
        3'd2:       flags = 9'h090;
        3'd3:       flags = 9'h0A0;
        3'd4:       flags[8] = 1'b1;
        default:    flags = '0;
      endcase
    endcase
  end

  always_comb begin
    disp = '0;
    ext1 = '0;
    ext2 = '0;
    if (is_imm) begin
      if (sz <= 4'd1)      disp = {{24{acc[7]}}, acc[7:0]};
      else if (sz == 4'd2) disp = {{16{acc[15]}}, acc[15:0]};
      else if (sz <= 4'd4) disp = acc[31:0];
      else if (sz <= 4'd8) begin
        disp = acc[63:32];
        ext1 = acc[31:0];
      end else begin
        disp = acc[95:64];
        ext1 = acc[63:32];
        ext2 = acc[31:0];
      end
    end else if (md == 3'd7 && rf == 3'd1) begin
      disp = acc[31:0];
    end else if (md == 3'd5 || (md == 3'd7 && (rf == 3'd0 || rf == 3'd2))) begin
      disp = {{16{acc[15]}}, acc[15:0]};
    end
  end

endmodule

module ea_mode_decoder_chk #(
  parameter int CNT_W = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          wd_ready,
  input logic          done,
  input logic          bus_err,
  input logic          illegal,
  input logic [8:0]    flags,
  input logic [CNT_W:0] adv_bytes
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> req_ready); // R11
  AST_NO_WORD_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !wd_ready); // R11
  AST_ILLEGAL_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n) (done && illegal) |-> (adv_bytes == 0 && flags == 0)); // R7
  AST_OFFSET_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n) (done && !bus_err && flags == 9'h010) |-> adv_bytes == 2); // R3
  AST_PCREL_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n) (done && !bus_err && flags == 9'h090) |-> adv_bytes == 2); // R6
  AST_INDEXED_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n) (done && flags[5]) |-> adv_bytes == 0); // R4
  AST_ABS_WORDS: assert property (@(posedge clk) disable iff (!rst_n) (done && !bus_err && flags[6]) |-> (adv_bytes == 2 || adv_bytes == 4)); // R5
  AST_FAULT_NOT_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n) (done && bus_err) |-> !illegal); // R10
  AST_FLAG_COUNT: assert property (@(posedge clk) disable iff (!rst_n) done |-> $countones(flags) <= 2); // R2
endmodule

bind ea_mode_decoder ea_mode_decoder_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .wd_ready(wd_ready),
  .done(done), .bus_err(bus_err), .illegal(illegal), .flags(flags),
  .adv_bytes(adv_bytes)
);

// File: tb/ea_mode_decoder_tb_top.sv
module ea_mode_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  mode_reg = '0;
  logic [3:0]  data_size = '0;
  logic        wd_valid = 1'b0;
  logic        wd_ready;
  logic [15:0] wd_data = '0;
  logic        wd_fault = 1'b0;
  logic        done, bus_err, illegal;
  logic [3:0]  reg_num;
  logic [8:0]  flags;
  logic [31:0] disp, ext1, ext2;
  logic [3:0]  adv_bytes;

  int total = 0;
  int bad = 0;
  logic [15:0] wbuf [0:5];

  always #2 clk = ~clk;

  ea_mode_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mode_reg(mode_reg), .data_size(data_size), .wd_valid(wd_valid),
    .wd_ready(wd_ready), .wd_data(wd_data), .wd_fault(wd_fault), .done(done),
    .bus_err(bus_err), .illegal(illegal), .reg_num(reg_num), .flags(flags),
    .disp(disp), .ext1(ext1), .ext2(ext2), .adv_bytes(adv_bytes)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [5:0] m, input logic [3:0] s, input int fault_at,
                     input string tag, input logic [3:0] e_reg, input logic [8:0] e_flags,
                     input logic [31:0] e_disp, input logic [31:0] e_x1, input logic [31:0] e_x2,
                     input logic [3:0] e_adv, input logic e_ill, input logic e_err);
    int i = 0;
    bit got = 0;
    @(negedge clk);
    chk(req_ready, {tag, " R11 ready before request"}, 32'(req_ready), 1);
    req_valid = 1'b1; mode_reg = m; data_size = s;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready || done, {tag, " R11 busy after accept"}, 32'(req_ready), 0);
    for (int c = 0; c < 20; c++) begin
      if (done) begin got = 1; break; end
      wd_valid = 1'b0; wd_fault = 1'b0;
      if (wd_ready) begin
        wd_valid = 1'b1;
        wd_data = wbuf[i];
        wd_fault = (i == fault_at);
      end
      @(negedge clk);
      if (wd_valid && !wd_fault) i++;
      wd_valid = 1'b0; wd_fault = 1'b0;
    end
    chk(got, {tag, " R11 done seen"}, 32'(got), 1);
    chk(reg_num == e_reg, {tag, " R1 reg_num"}, 32'(reg_num), 32'(e_reg));
    chk(flags == e_flags, {tag, " R2 flags"}, 32'(flags), 32'(e_flags));
    chk(disp == e_disp, {tag, " disp"}, disp, e_disp);
    chk(ext1 == e_x1 && ext2 == e_x2, {tag, " R9 ext words"}, ext1 ^ ext2, e_x1 ^ e_x2);
    chk(adv_bytes == e_adv, {tag, " adv_bytes"}, 32'(adv_bytes), 32'(e_adv));
    chk(illegal == e_ill, {tag, " R7 illegal"}, 32'(illegal), 32'(e_ill));
    chk(bus_err == e_err, {tag, " R10 bus_err"}, 32'(bus_err), 32'(e_err));
    @(negedge clk);
    chk(!done && req_ready, {tag, " R11 single done, ready after"}, {30'd0, done, req_ready}, 32'd1);
  endtask

  task automatic t_reset;
    chk(req_ready && !done && !wd_ready, "R11 reset state", {29'd0, req_ready, done, wd_ready}, 32'h4);
  endtask

  task automatic t_register_modes;
    run(6'o03, 0, -1, "R1 R2 m0", 4'd3,  9'h001, 0, 0, 0, 0, 0, 0);
    run(6'o15, 0, -1, "R1 R2 m1", 4'd13, 9'h001, 0, 0, 0, 0, 0, 0);
    run(6'o27, 0, -1, "R2 m2",    4'd15, 9'h002, 0, 0, 0, 0, 0, 0);
    run(6'o30, 0, -1, "R2 m3",    4'd8,  9'h004, 0, 0, 0, 0, 0, 0);
    run(6'o44, 0, -1, "R2 m4",    4'd12, 9'h008, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_offset;
    wbuf[0] = 16'h8001;
    run(6'o52, 0, -1, "R3 neg", 4'd10, 9'h010, 32'hFFFF8001, 0, 0, 4'd2, 0, 0);
    wbuf[0] = 16'h7FF0;
    run(6'o57, 0, -1, "R3 pos", 4'd15, 9'h010, 32'h00007FF0, 0, 0, 4'd2, 0, 0);
  endtask

  task automatic t_indexed;
    run(6'o61, 0, -1, "R4 m6",  4'd9, 9'h020, 0, 0, 0, 0, 0, 0);
    run(6'o73, 0, -1, "R4 pcx", 4'd3, 9'h0A0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_absolute;
    wbuf[0] = 16'h1234;
    run(6'o70, 0, -1, "R5 absw", 4'd0, 9'h040, 32'h00001234, 0, 0, 4'd2, 0, 0);
    wbuf[0] = 16'hDEAD; wbuf[1] = 16'hBEEF;
    run(6'o71, 0, -1, "R5 absl", 4'd1, 9'h040, 32'hDEADBEEF, 0, 0, 4'd4, 0, 0);
  endtask

  task automatic t_pcrel;
    wbuf[0] = 16'hFFFE;
    run(6'o72, 0, -1, "R6 pcd", 4'd2, 9'h090, 32'hFFFFFFFE, 0, 0, 4'd2, 0, 0);
  endtask

  task automatic t_illegal;
    for (int r = 5; r < 8; r++)
      run({3'd7, 3'(r)}, 0, -1, "R7 bad", 4'(r), 9'h000, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_imm_short;
    wbuf[0] = 16'h3380;
    run(6'o74, 4'd1, -1, "R8 byte", 4'd4, 9'h100, 32'hFFFFFF80, 0, 0, 4'd2, 0, 0);
    wbuf[0] = 16'h7FFF;
    run(6'o74, 4'd2, -1, "R8 word", 4'd4, 9'h100, 32'h00007FFF, 0, 0, 4'd2, 0, 0);
  endtask

  task automatic t_imm_long;
    wbuf[0] = 16'h1234; wbuf[1] = 16'h5678; wbuf[2] = 16'h9ABC;
    wbuf[3] = 16'hDEF0; wbuf[4] = 16'hCAFE; wbuf[5] = 16'hF00D;
    run(6'o74, 4'd4,  -1, "R9 long", 4'd4, 9'h100, 32'h12345678, 0, 0, 4'd4, 0, 0);
    run(6'o74, 4'd8,  -1, "R9 dbl",  4'd4, 9'h100, 32'h12345678, 32'h9ABCDEF0, 0, 4'd8, 0, 0);
    run(6'o74, 4'd12, -1, "R9 ext",  4'd4, 9'h100, 32'h12345678, 32'h9ABCDEF0, 32'hCAFEF00D, 4'd12, 0, 0);
  endtask

  task automatic t_fault;
    wbuf[0] = 16'hAAAA; wbuf[1] = 16'hBBBB;
    run(6'o71, 0, 1, "R10 2nd", 4'd1, 9'h040, 32'h0000AAAA, 0, 0, 4'd2, 0, 1);
    run(6'o50, 0, 0, "R10 1st", 4'd8, 9'h010, 32'h00000000, 0, 0, 4'd0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_register_modes();
    t_offset();
    t_indexed();
    t_absolute();
    t_pcrel();
    t_illegal();
    t_imm_short();
    t_imm_long();
    t_fault();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL R11 watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule